// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address. It does this by reading a two-level page table held in memory. A request is accepted only while the walker is idle. The walker then makes two reads, one after the other, on a read port that allows only one outstanding read:

- The first read fetches a directory entry. Its address comes from the directory base page, taken from a control-register input, and the top ten linear bits.
- The second read fetches a table entry. Its address comes from the table page named by the directory entry, and the next ten linear bits.

Pages are 4096 bytes. The low twelve address bits are never translated. Bit 0 of every entry is the present flag.

Every walk ends with a one-cycle completion pulse. The pulse carries one of two results:

- A successful walk returns the physical address.
- If either entry lacks its present flag, the walk ends in a page fault. The faulting linear address is then latched into a fault-address register, which stays visible on an output until the next fault.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. A `req_valid` seen while `req_ready` is low starts no walk and issues no read. A request held high across a walk is taken in the first idle cycle.
- R2: The first read of a walk goes to address `{dir_base[31:12], lin[31:22], 2'b00}`, using the base value present in the cycle the request is accepted.
- R3: When the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], lin[21:12], 2'b00}`.
- R4: Only one read is outstanding at a time. No new read is issued between a read request and its response.
- R5: When both entries have bit 0 set, the completion carries `fault=0` and the physical address `{tbl_entry[31:12], lin[11:0]}`.
- R6: A directory entry with bit 0 clear ends the walk in a fault, and no second read is issued.
- R7: A table entry with bit 0 clear ends the walk in a fault.
- R8: On a fault, `fault_lin_addr` takes the walk's linear address by the cycle of the completion pulse. A successful walk leaves it unchanged.
- R9: `done_valid` is high for exactly one cycle per accepted request, and `req_ready` is high in the following cycle.
- R10: Bits 11:0 of the base input and entry bits 11:1 have no effect on read addresses, results or faults.
- R11: After reset the walker is idle, `done_valid` and `mem_req_valid` are low, and `fault_lin_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_lin | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle; request taken when both high |
| dir_base | input | 32 | Control value; bits 31:12 are the directory page |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Read address (entry address) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion is a page fault |
| done_pa | output | 32 | Physical address (valid when no fault) |
| fault_lin_addr | output | 32 | Linear address of the most recent fault |

## Verification
Two events can fall in the same cycle. The first is the completion pulse of one walk, which for a fault coincides with the fault-address update. The second is a new request that has been held waiting at the input. The bench provokes this by issuing requests back to back, so the second one waits through the whole walk and the pulse cycle. A cycle-level model predicts `req_ready` on every clock. It also predicts the ordered list of read addresses, so a request taken one cycle early appears as a read that was not expected. The bench also shows that a short request pulse during a busy walk leaves no trace, and it checks the fault-address register in the pulse cycle against the model.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW      = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int ESZ_LG  = 2;
  localparam int PFN_W   = AW - OFF_W;

  typedef logic [AW-1:0]    addr_t;
  typedef logic [PFN_W-1:0] pfn_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_FIN
  } ptw_state_e;

  function automatic addr_t entry_addr(pfn_t base, idx_t idx);
    return {base, idx, {ESZ_LG{1'b0}}};
  endfunction

  function automatic idx_t dir_index(addr_t lin);
    return lin[AW-1 -: IDX_W];
  endfunction

  function automatic idx_t tbl_index(addr_t lin);
    return lin[OFF_W +: IDX_W];
  endfunction

  function automatic pfn_t frame_of(addr_t v);
    return v[AW-1 -: PFN_W];
  endfunction

  function automatic addr_t compose_pa(pfn_t frame, addr_t lin);
    return {frame, lin[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import ptw_pkg::*;
(
  input  logic [PFN_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  always_comb addr = entry_addr(base, idx);
endmodule

// File: rtl/ptw_fault_reg.sv
module ptw_fault_reg
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] lin,
  output logic [AW-1:0] fault_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       fault_addr <= '0;
    else if (capture) fault_addr <= lin;
  end

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (fault_addr == $past(lin)));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int PRESENT_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_lin,
  output logic          req_ready,
  input  logic [31:0]   dir_base,
  output logic          mem_req_valid,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          done_valid,
  output logic          done_fault,
  output logic [31:0]   done_pa,
  output logic [31:0]   fault_lin_addr
);
  ptw_state_e state_q;
  addr_t      lin_q;
  pfn_t       base_q;
  logic       fault_q;
  addr_t      pa_q;

  // named internal events
  logic accept, rsp_present, dir_hit, dir_miss, tbl_hit, tbl_miss, walk_fault;
  idx_t lvl_idx;

  assign req_ready     = (state_q == S_IDLE);
  assign accept        = req_valid && req_ready;
  assign rsp_present   = mem_rsp_data[PRESENT_BIT];
  assign dir_hit       = (state_q == S_L1_WAIT) && mem_rsp_valid &&  rsp_present;
  assign dir_miss      = (state_q == S_L1_WAIT) && mem_rsp_valid && !rsp_present;
  assign tbl_hit       = (state_q == S_L2_WAIT) && mem_rsp_valid &&  rsp_present;
  assign tbl_miss      = (state_q == S_L2_WAIT) && mem_rsp_valid && !rsp_present;
  assign walk_fault    = dir_miss || tbl_miss;
  assign lvl_idx       = (state_q == S_L1_REQ) ? dir_index(lin_q) : tbl_index(lin_q);
  assign mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign done_valid    = (state_q == S_FIN);
  assign done_fault    = fault_q;
  assign done_pa       = pa_q;

  ptw_entry_addr u_addr (
    .base (base_q),
    .idx  (lvl_idx),
    .addr (mem_req_addr)
  );

  ptw_fault_reg u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (walk_fault),
    .lin        (lin_q),
    .fault_addr (fault_lin_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lin_q   <= '0;
      base_q  <= '0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          lin_q   <= req_lin;
          base_q  <= frame_of(dir_base);
          fault_q <= 1'b0;
          pa_q    <= '0;
          state_q <= S_L1_REQ;
        end
        S_L1_REQ: state_q <= S_L1_WAIT;
        S_L1_WAIT: begin
          if (dir_hit) begin
            base_q  <= frame_of(mem_rsp_data);
            state_q <= S_L2_REQ;
          end else if (dir_miss) begin
            fault_q <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_L2_REQ: state_q <= S_L2_WAIT;
        S_L2_WAIT: begin
          if (tbl_hit) begin
            pa_q    <= compose_pa(frame_of(mem_rsp_data), lin_q);
            state_q <= S_FIN;
          end else if (tbl_miss) begin
            fault_q <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r1_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(lin_q));
  a_r4_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  a_r6_dir_miss_ends: assert property (@(posedge clk) disable iff (!rst_n)
    dir_miss |=> (done_valid && done_fault && !mem_req_valid));
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_pa[OFF_W-1:0] == lin_q[OFF_W-1:0]));
  a_r8_hold_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> $stable(fault_lin_addr));
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        req_ready;
  logic [31:0] dir_base = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid, done_fault;
  logic [31:0] done_pa, fault_lin_addr;

  always #2.5 clk = ~clk;

  pt_walker dut (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr [$];
  string       exp_atag [$];
  logic [31:0] exp_res  [$];
  logic        exp_flt  [$];
  logic [31:0] exp_lin  [$];
  string       exp_rtag [$];
  bit          model_busy = 0, prev_done = 0, pend = 0, mon_on = 0;
  int          lat = 0, cnt = 0, acc_cnt = 0, cyc = 0;
  logic [31:0] pend_addr, cr2_model = '0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // behavioural reference walk: masks and arithmetic, pushes expected reads and result
  function automatic void model_walk(logic [31:0] lin, logic [31:0] base);
    logic [31:0] da, d, ta, t;
    da = (base & 32'hFFFF_F000) + (lin >> 22) * 4;
    exp_addr.push_back(da); exp_atag.push_back("R2");
    d = rd(da);
    exp_lin.push_back(lin);
    if (d % 2 == 0) begin
      exp_flt.push_back(1); exp_res.push_back(0); exp_rtag.push_back("R6");
      return;
    end
    ta = (d & 32'hFFFF_F000) + ((lin >> 12) & 32'h3FF) * 4;
    exp_addr.push_back(ta); exp_atag.push_back("R3");
    t = rd(ta);
    if (t % 2 == 0) begin
      exp_flt.push_back(1); exp_res.push_back(0); exp_rtag.push_back("R7");
    end else begin
      exp_flt.push_back(0); exp_res.push_back((t & 32'hFFFF_F000) | (lin & 32'hFFF));
      exp_rtag.push_back("R5");
    end
  endfunction

  // per-clock model comparison and memory responder
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      check(req_ready == !model_busy, "R1", "req_ready", req_ready, !model_busy);
      if (done_valid) begin
        logic [31:0] e_res, e_lin; logic e_f; string tg;
        check(!prev_done, "R9", "pulse width", 2, 1);
        if (exp_flt.size() == 0) check(0, "R9", "unexpected done", 1, 0);
        else begin
          e_res = exp_res.pop_front(); e_f = exp_flt.pop_front();
          e_lin = exp_lin.pop_front(); tg = exp_rtag.pop_front();
          check(done_fault == e_f, tg, "fault flag", done_fault, e_f);
          if (!e_f) check(done_pa == e_res, "R5", "phys addr", done_pa, e_res);
          if (e_f) cr2_model = e_lin;
          check(fault_lin_addr == cr2_model, "R8", "fault addr", fault_lin_addr, cr2_model);
        end
        model_busy = 0;
      end
      prev_done = done_valid;
      if (req_valid && req_ready) begin
        model_walk(req_lin, dir_base);
        model_busy = 1;
        acc_cnt++;
      end
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1; mem_rsp_data <= rd(pend_addr); pend = 0;
        end else cnt--;
      end
      if (mem_req_valid) begin
        check(!pend, "R4", "read while outstanding", 1, 0);
        if (exp_addr.size() == 0) check(0, "R6", "unexpected read", mem_req_addr, 0);
        else begin
          logic [31:0] ea; string at;
          ea = exp_addr.pop_front(); at = exp_atag.pop_front();
          check(mem_req_addr == ea, at, "read addr", mem_req_addr, ea);
        end
        pend = 1; pend_addr = mem_req_addr; cnt = lat;
      end
    end
  end

  task automatic issue(logic [31:0] lin);
    int target;
    target = acc_cnt + 1;
    @(posedge clk); #1;
    req_valid = 1'b1; req_lin = lin;
    do begin @(posedge clk); #1; end while (acc_cnt < target);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (model_busy || exp_flt.size() != 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    // table contents: low entry bits carry junk to exercise R10
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_000C] = 32'h1234_5F01;
    mem[32'h0001_0FFC] = 32'h0003_0FFF;
    mem[32'h0003_0FFC] = 32'hFFFF_F001;
    mem[32'h0002_0014] = 32'hABCD_EFFE;
    mem[32'h0005_0000] = 32'h0006_0001;
    mem[32'h0006_0000] = 32'h0000_0001;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1, "R11", "ready after reset", req_ready, 1);
    check(done_valid == 0, "R11", "done after reset", done_valid, 0);
    check(mem_req_valid == 0, "R11", "read after reset", mem_req_valid, 0);
    check(fault_lin_addr == 0, "R11", "fault addr after reset", fault_lin_addr, 0);
    mon_on = 1;
    for (int l = 0; l < 4; l++) begin
      lat = l;
      dir_base = 32'h0001_0000;
      issue(32'h0040_3ABC); wait_idle();   // R5 mapped
      issue(32'hFFFF_FFFF); wait_idle();   // R5 top indices
      issue(32'h0080_0123); wait_idle();   // R6 directory miss
      issue(32'h0040_5000); wait_idle();   // R7 table miss
      issue(32'h0040_3001); wait_idle();   // R8 success keeps fault addr
      dir_base = 32'h0005_0FFF;            // R10 low base bits ignored
      issue(32'h0000_0ABC); wait_idle();
    end
    // R1: back-to-back requests, second held through first walk and pulse
    lat = 1;
    dir_base = 32'h0001_0000;
    issue(32'h0040_3111);
    issue(32'h0080_0222);
    issue(32'hFFFF_F333);
    wait_idle();
    // R1: short pulse while busy must start nothing
    issue(32'h0040_3444);
    @(posedge clk); #1;
    req_valid = 1'b1; req_lin = 32'h0080_0000;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_idle();
    repeat (10) @(posedge clk);
    check(exp_addr.size() == 0, "R1", "reads outstanding in model", exp_addr.size(), 0);
    check(acc_cnt == 28, "R9", "accepted count", acc_cnt, 28);
    finish_run();
  end
endmodule